// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers the interrupt sources of a byte-wide peripheral into one request line. It has seven sources: two timers, a serial shift register and four control lines. Each source owns one pending bit in a flag register and one mask bit in an enable register. A source marks its bit pending with a one-cycle set pulse, or by reporting a level. A bit stops pending when software writes a 1 to it, when a clear strobe from another part of the peripheral hits it, or when a level source reports 0. Reading the shift-register data address also clears the shift-register bit.

Software sees both registers as bytes. The flag byte carries, in bit 7, a live summary: bit 7 is 1 when any pending bit is also enabled. The enable byte always reads with bit 7 at 1. A write to the enable byte uses data bit 7 to choose the mode: with bit 7 at 1 the write turns the selected enables on, and with bit 7 at 0 it turns them off. The request output is registered and follows the pending-and-enabled condition one clock later.

Top module: `intflag_ctl`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, the flag byte reads 0x00, the enable byte reads 0x80 and `irq_o` is 0.
- R2: `irq_o` is registered. It is 1 in the cycle after one in which the pending bits ANDed with the enable bits are nonzero, and 0 in the cycle after one in which that AND is zero.
- R3: A flag-byte write clears every pending bit whose data bit (6:0) is 1 and leaves the other pending bits unchanged. Data bit 7 has no effect.
- R4: An enable-byte write with data bit 7 at 1 ORs data bits 6:0 into the enables.
- R5: An enable-byte write with data bit 7 at 0 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R6: The enable byte reads as the seven enables in bits 6:0, with bit 7 always 1.
- R7: The flag byte reads as the seven pending bits in bits 6:0. Bit 7 is 1 in the same cycle that any pending bit is also enabled.
- R8: A read strobe on the shift-register data address clears pending bit 2 (the shift register) and no other bit.
- R9: A set pulse on bit i makes pending bit i 1 at the next clock. The bit positions are: 6 timer 1, 5 timer 2, 4 control line B1, 3 control line B2, 2 shift register, 1 control line A1, 0 control line A2.
- R10: When a level-source update is strobed on bit i, pending bit i takes the reported level: 1 sets it and 0 clears it.
- R11: If a set (a pulse, or a level update at 1) and any clear hit the same bit in one cycle, the bit ends up pending.
- R12: A side-effect clear strobe on bit i clears pending bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_flag | input | 1 | Write strobe for the flag byte |
| wr_mask | input | 1 | Write strobe for the enable byte |
| wdata | input | 8 | Write data |
| sr_rd | input | 1 | Read strobe of the shift-register data address |
| set_pulse | input | 7 | Per-bit set pulses from the sources |
| clr_strobe | input | 7 | Per-bit side-effect clear strobes |
| lvl_upd | input | 7 | Per-bit level-source update strobes |
| lvl_val | input | 7 | Level reported with each update |
| flag_rd | output | 8 | Flag byte read value (summary in bit 7) |
| mask_rd | output | 8 | Enable byte read value (bit 7 always 1) |
| irq_o | output | 1 | Registered active-high interrupt request |

## Verification
The assertions assume that every strobe is sampled on the clock edge. A strobe that is held for several cycles acts again on each of those cycles, so the clear checks only hold when no set on the same bit arrives in the same cycle. For that reason the clear properties exclude that case in their antecedent. The bench drives all stimulus on the falling edge and holds it for exactly one cycle. It then idles, so every change of `flag_rd`, `mask_rd` and `irq_o` can be predicted from that single cycle. The bench creates same-cycle collisions on purpose, only in the scenario that checks set priority.

// File: rtl/intflag_ctl.sv
module intflag_ctl #(
  parameter int NSRC   = 7,
  parameter int SR_IDX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_flag,
  input  logic            wr_mask,
  input  logic [NSRC:0]   wdata,
  input  logic            sr_rd,
  input  logic [NSRC-1:0] set_pulse,
  input  logic [NSRC-1:0] clr_strobe,
  input  logic [NSRC-1:0] lvl_upd,
  input  logic [NSRC-1:0] lvl_val,
  output logic [NSRC:0]   flag_rd,
  output logic [NSRC:0]   mask_rd,
  output logic            irq_o
);

  localparam logic [NSRC-1:0] SR_BIT = NSRC'(1) << SR_IDX;

  logic [NSRC-1:0] pend_q, mask_q, pend_d, mask_d;
  logic [NSRC-1:0] set_v, clr_v, wdat;
  logic            hit;

  assign wdat  = wdata[NSRC-1:0];
  assign set_v = set_pulse | (lvl_upd & lvl_val);
  assign clr_v = clr_strobe
               | (wr_flag ? wdat : '0)
               | (sr_rd ? SR_BIT : '0)
               | (lvl_upd & ~lvl_val);
  assign pend_d = (pend_q & ~clr_v) | set_v;

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) begin
      if (wdata[NSRC]) mask_d = mask_q | wdat;
      else             mask_d = mask_q & ~wdat;
    end
  end

  assign hit = |(pend_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq_o  <= hit;
    end
  end

  assign flag_rd = {hit, pend_q};
  assign mask_rd = {1'b1, mask_q};

endmodule

// File: rtl/intflag_ctl_chk.sv
module intflag_ctl_chk #(
  parameter int NSRC = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_flag,
  input logic            wr_mask,
  input logic [NSRC:0]   wdata,
  input logic            sr_rd,
  input logic [NSRC-1:0] set_pulse,
  input logic [NSRC-1:0] lvl_upd,
  input logic [NSRC-1:0] lvl_val,
  input logic [NSRC:0]   flag_rd,
  input logic [NSRC:0]   mask_rd,
  input logic            irq_o
);

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(flag_rd[NSRC-1:0] & mask_rd[NSRC-1:0]))); // R2

  AST_MASK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd[NSRC]); // R6

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> (flag_rd[NSRC-1:0] & $past(set_pulse)) == $past(set_pulse)); // R11

  AST_WFLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && set_pulse == '0 && (lvl_upd & lvl_val) == '0)
      |=> (flag_rd[NSRC-1:0] & $past(wdata[NSRC-1:0])) == '0); // R3

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && wdata[NSRC])
      |=> (mask_rd[NSRC-1:0] & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])); // R4

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !wdata[NSRC])
      |=> (mask_rd[NSRC-1:0] & $past(wdata[NSRC-1:0])) == '0); // R5

  AST_SR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd && !set_pulse[2] && !(lvl_upd[2] && lvl_val[2])) |=> !flag_rd[2]); // R8

endmodule

bind intflag_ctl intflag_ctl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_flag(wr_flag), .wr_mask(wr_mask),
  .wdata(wdata), .sr_rd(sr_rd), .set_pulse(set_pulse),
  .lvl_upd(lvl_upd), .lvl_val(lvl_val),
  .flag_rd(flag_rd), .mask_rd(mask_rd), .irq_o(irq_o)
);

// File: tb/sim_intflag_ctl.sv
module sim_intflag_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_flag = 1'b0, wr_mask = 1'b0, sr_rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [6:0] set_pulse = '0, clr_strobe = '0, lvl_upd = '0, lvl_val = '0;
  logic [7:0] flag_rd, mask_rd;
  logic       irq_o;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  intflag_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wr_flag(wr_flag), .wr_mask(wr_mask),
    .wdata(wdata), .sr_rd(sr_rd), .set_pulse(set_pulse),
    .clr_strobe(clr_strobe), .lvl_upd(lvl_upd), .lvl_val(lvl_val),
    .flag_rd(flag_rd), .mask_rd(mask_rd), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr_flag = 0; wr_mask = 0; sr_rd = 0; wdata = '0;
    set_pulse = '0; clr_strobe = '0; lvl_upd = '0; lvl_val = '0;
  endtask

  task automatic wipe();
    wr_flag = 1; wdata = 8'hFF; step();
    wr_mask = 1; wdata = 8'h7F; step();
    step();
  endtask

  task automatic t_reset();
    chk("R1 flag", flag_rd, 8'h00);
    chk("R1 mask", mask_rd, 8'h80);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_irq();
    set_pulse = 7'h40; step();
    chk("R9 timer1 set", flag_rd, 8'h40);
    chk("R2 masked irq", {7'd0, irq_o}, 8'h00);
    wr_mask = 1; wdata = 8'hC0; step();
    chk("R4 mask set", mask_rd, 8'hC0);
    chk("R7 live summary", flag_rd, 8'hC0);
    chk("R2 lag low", {7'd0, irq_o}, 8'h00);
    step();
    chk("R2 irq high", {7'd0, irq_o}, 8'h01);
    wr_flag = 1; wdata = 8'h40; step();
    chk("R3 flag cleared", flag_rd, 8'h00);
    chk("R2 lag high", {7'd0, irq_o}, 8'h01);
    step();
    chk("R2 irq low", {7'd0, irq_o}, 8'h00);
    wipe();
  endtask

  task automatic t_mask_modes();
    wr_mask = 1; wdata = 8'h8F; step();
    chk("R4 or-in", mask_rd, 8'h8F);
    wr_mask = 1; wdata = 8'h05; step();
    chk("R5 clear mode", mask_rd, 8'h8A);
    wr_mask = 1; wdata = 8'h80; step();
    chk("R4 empty set", mask_rd, 8'h8A);
    wr_mask = 1; wdata = 8'h00; step();
    chk("R5 empty clear R6", mask_rd, 8'h8A);
    wipe();
  endtask

  task automatic t_flag_clear();
    set_pulse = 7'h7F; step();
    chk("R9 all sources", flag_rd, 8'h7F);
    wr_flag = 1; wdata = 8'h85; step();
    chk("R3 partial clear", flag_rd, 8'h7A);
    wipe();
  endtask

  task automatic t_summary();
    wr_mask = 1; wdata = 8'h82; step();
    set_pulse = 7'h01; step();
    chk("R7 unmasked pending", flag_rd, 8'h01);
    set_pulse = 7'h02; step();
    chk("R7 masked pending", flag_rd, 8'h83);
    wipe();
  endtask

  task automatic t_sr();
    set_pulse = 7'h05; step();
    sr_rd = 1; step();
    chk("R8 sr read clear", flag_rd, 8'h01);
    wipe();
  endtask

  task automatic t_level();
    set_pulse = 7'h02; step();
    lvl_upd = 7'h12; lvl_val = 7'h10; step();
    chk("R10 level update", flag_rd, 8'h10);
    wipe();
  endtask

  task automatic t_set_wins();
    set_pulse = 7'h24; wr_flag = 1; wdata = 8'h24; clr_strobe = 7'h20; sr_rd = 1; step();
    chk("R11 set beats clear", flag_rd, 8'h24);
    lvl_upd = 7'h08; lvl_val = 7'h08; clr_strobe = 7'h08; step();
    chk("R11 level beats strobe", flag_rd, 8'h2C);
    wipe();
  endtask

  task automatic t_strobe();
    set_pulse = 7'h48; step();
    clr_strobe = 7'h08; step();
    chk("R12 side clear", flag_rd, 8'h40);
    wipe();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_irq();
    t_mask_modes();
    t_flag_clear();
    t_summary();
    t_sr();
    t_level();
    t_set_wins();
    t_strobe();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule